// File: doc/BRIEF.md
# Serial Time Image Port

This block is the slave side of a three-wire serial port that moves a complete 52-bit clock and calendar image in either direction. The host drives a chip enable, a direction select, a serial clock, and one data line. Inside the chip the data line is split into an input and an output with an enable. All four serial inputs are resynchronised into a faster system clock, and the block acts on edges it detects there.

In a read, the first rising serial clock edge captures the live calendar image into a shift register and presents bit 0. Each further rising edge presents the next bit. In a write, bits are taken on rising edges, least significant first, into an assembly register. The whole image is handed to the calendar as one commit pulse on the 52nd edge. On the first falling serial clock edge of a write, the block pulses a sub-second divider reset. It then holds a carry-inhibit level until chip enable drops. The calendar counters themselves live outside this block.

Top module: `ser_time_port`

## Requirements
- R1: After reset the data output enable, the commit pulse, the divider reset pulse and the carry inhibit are all 0, and the committed image is all zeros.
- R2: The data output enable is 1 only while chip enable is high and the direction input is 0 (read). It is 0 in write mode and whenever chip enable is low.
- R3: In a read, rising serial clock edge k (k = 1..52) makes the data output show bit k-1 of the image captured at edge 1. Changes to the calendar input after edge 1 do not affect that frame.
- R4: In a read, after the 52nd rising edge the data output keeps showing bit 51, however many extra edges arrive.
- R5: Dropping chip enable ends a read early. The next read starts again at bit 0 with a fresh capture.
- R6: In a write with direction 1, the bit sampled at rising edge k becomes bit k-1 of the image. At the 52nd edge the committed image is updated and a single one-cycle commit pulse is issued.
- R7: Rising edges after the 52nd in the same write change neither the committed image nor produce another commit pulse.
- R8: A write whose chip enable falls before the 52nd edge produces no commit pulse and leaves the committed image unchanged.
- R9: On the first falling serial clock edge of a write, a one-cycle divider reset pulse is issued and the carry inhibit rises. The inhibit stays at 1 until chip enable goes low. A read never raises either signal.
- R10: While chip enable is low, serial clock and data activity has no effect: no output enable, no commit, no divider reset, and no advance of the bit position.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Serial chip enable, active high |
| dir_i | input | 1 | Direction select: 1 write, 0 read |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data from the host |
| sdat_o | output | 1 | Serial data to the host |
| sdat_oe_o | output | 1 | Drive enable for the data line |
| time_img_i | input | 52 | Live calendar image captured at the start of a read |
| wr_img_o | output | 52 | Last fully written image |
| wr_commit_o | output | 1 | One-cycle pulse when wr_img_o takes a new image |
| div_rst_o | output | 1 | One-cycle pulse resetting the sub-second divider |
| carry_hold_o | output | 1 | Level that inhibits seconds carries during a write |

## Verification
The bench goes after the frame boundaries. A design that counted edges off by one would commit on the 51st or 53rd bit, or read out a shifted image. One that kept shifting past 52 would output zeros on extra read clocks or overwrite the image on extra write clocks. Truncated writes are checked for a stray commit, since a design that committed on chip enable falling would corrupt the year field. Reads that change the calendar input mid-frame expose a missing snapshot. Serial clock toggles while chip enable is low expose a bit counter that is not gated, because the following read would then start at the wrong bit.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int TSP_FRAME_W = 52;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } tsp_mode_e;
endpackage

// File: rtl/tsp_sync.sv
module tsp_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl
  import tsp_pkg::*;
#(
  parameter int W  = TSP_FRAME_W,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          dir_s,
  input  logic          sclk_s,
  output logic          rd_load,
  output logic          rd_shift,
  output logic          wr_shift,
  output logic          wr_last,
  output logic [CW-1:0] cnt_q,
  output logic          oe_q,
  output logic          commit_q,
  output logic          div_rst_q,
  output logic          hold_q
);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  tsp_mode_e     mode;
  logic          sclk_q;
  logic          rise, fall, open;
  logic          first_fall;
  logic [CW-1:0] cnt_d;
  logic          hold_d;

  assign mode       = tsp_mode_e'(dir_s);
  assign rise       = ce_s & sclk_s & ~sclk_q;
  assign fall       = ce_s & ~sclk_s & sclk_q;
  assign open       = (cnt_q != FULL);
  assign rd_load    = rise & (mode == MODE_RD) & (cnt_q == '0);
  assign rd_shift   = rise & (mode == MODE_RD) & (cnt_q != '0) & open;
  assign wr_shift   = rise & (mode == MODE_WR) & open;
  assign wr_last    = wr_shift & (cnt_q == LAST);
  assign first_fall = fall & (mode == MODE_WR) & (cnt_q == ONE) & ~hold_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!ce_s)             cnt_d = '0;
    else if (rise && open) cnt_d = cnt_q + ONE;
  end

  always_comb begin
    hold_d = hold_q;
    if (!ce_s)           hold_d = 1'b0;
    else if (first_fall) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cnt_q     <= '0;
      oe_q      <= 1'b0;
      commit_q  <= 1'b0;
      div_rst_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      cnt_q     <= cnt_d;
      oe_q      <= ce_s & (mode == MODE_RD);
      commit_q  <= wr_last;
      div_rst_q <= first_fall;
      hold_q    <= hold_d;
    end
  end
endmodule

// File: rtl/tsp_shift.sv
module tsp_shift #(
  parameter int W = 52
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_load,
  input  logic         rd_shift,
  input  logic         wr_shift,
  input  logic         wr_last,
  input  logic         din_s,
  input  logic [W-1:0] snap_i,
  output logic         dout,
  output logic [W-1:0] img_q
);
  logic [W-1:0] rd_q, rd_d;
  logic [W-1:0] wr_q, wr_d;

  always_comb begin
    rd_d = rd_q;
    if (rd_load)       rd_d = snap_i;
    else if (rd_shift) rd_d = {1'b0, rd_q[W-1:1]};
  end

  assign wr_d = {din_s, wr_q[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      img_q <= '0;
    end else begin
      rd_q <= rd_d;
      if (wr_shift) wr_q  <= wr_d;
      if (wr_last)  img_q <= wr_d;
    end
  end

  assign dout = rd_q[0];
endmodule

// File: rtl/ser_time_port.sv
module ser_time_port
  import tsp_pkg::*;
#(
  parameter int W = TSP_FRAME_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_i,
  input  logic         dir_i,
  input  logic         sclk_i,
  input  logic         sdat_i,
  output logic         sdat_o,
  output logic         sdat_oe_o,
  input  logic [W-1:0] time_img_i,
  output logic [W-1:0] wr_img_o,
  output logic         wr_commit_o,
  output logic         div_rst_o,
  output logic         carry_hold_o
);
  localparam int CW = $clog2(W + 1);

  logic [3:0]    pins_s;
  logic          ce_s, dir_s, sclk_s, din_s;
  logic          rd_load, rd_shift, wr_shift, wr_last;
  logic [CW-1:0] cnt_q;

  tsp_sync #(.N(4)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdat_i, sclk_i, dir_i, ce_i}),
    .sync_o  (pins_s)
  );

  assign {din_s, sclk_s, dir_s, ce_s} = pins_s;

  tsp_ctrl #(.W(W), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s      (ce_s),
    .dir_s     (dir_s),
    .sclk_s    (sclk_s),
    .rd_load   (rd_load),
    .rd_shift  (rd_shift),
    .wr_shift  (wr_shift),
    .wr_last   (wr_last),
    .cnt_q     (cnt_q),
    .oe_q      (sdat_oe_o),
    .commit_q  (wr_commit_o),
    .div_rst_q (div_rst_o),
    .hold_q    (carry_hold_o)
  );

  tsp_shift #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_load  (rd_load),
    .rd_shift (rd_shift),
    .wr_shift (wr_shift),
    .wr_last  (wr_last),
    .din_s    (din_s),
    .snap_i   (time_img_i),
    .dout     (sdat_o),
    .img_q    (wr_img_o)
  );
endmodule

// File: rtl/ser_time_port_chk.sv
module ser_time_port_chk #(
  parameter int W  = 52,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_s,
  input logic [CW-1:0] cnt_q,
  input logic          sdat_o,
  input logic          sdat_oe_o,
  input logic [W-1:0]  wr_img_o,
  input logic          wr_commit_o,
  input logic          div_rst_o,
  input logic          carry_hold_o
);
  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |=> !wr_commit_o);

  // R6
  commit_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> carry_hold_o);

  // R8
  img_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_img_o) |-> wr_commit_o);

  // R9
  div_rst_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst_o |=> carry_hold_o);

  // R9
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carry_hold_o) |-> $past(!ce_s));

  // R2
  oe_vs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdat_oe_o, div_rst_o}));

  // R4
  read_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(W) && ce_s) |=> $stable(sdat_o));
endmodule

bind ser_time_port ser_time_port_chk #(.W(W), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_s         (ce_s),
  .cnt_q        (cnt_q),
  .sdat_o       (sdat_o),
  .sdat_oe_o    (sdat_oe_o),
  .wr_img_o     (wr_img_o),
  .wr_commit_o  (wr_commit_o),
  .div_rst_o    (div_rst_o),
  .carry_hold_o (carry_hold_o)
);

// File: tb/tb_ser_time_port.sv
module tb_ser_time_port;
  localparam int W    = 52;
  localparam int HALF = 8;

  logic         clk, rst_n;
  logic         ce_i, dir_i, sclk_i, sdat_i;
  logic         sdat_o, sdat_oe_o;
  logic [W-1:0] time_img_i, wr_img_o;
  logic         wr_commit_o, div_rst_o, carry_hold_o;

  int checks = 0;
  int bad    = 0;
  int commits = 0;
  int divs    = 0;
  int cycles  = 0;
  logic [W-1:0] last_img;

  ser_time_port #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .dir_i(dir_i), .sclk_i(sclk_i),
    .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o),
    .time_img_i(time_img_i), .wr_img_o(wr_img_o), .wr_commit_o(wr_commit_o),
    .div_rst_o(div_rst_o), .carry_hold_o(carry_hold_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (wr_commit_o) commits++;
    if (div_rst_o)   divs++;
  end

  // fields: [59] write, [58:52] serial clock count, [51:0] image
  localparam logic [59:0] VEC [7] = '{
    {1'b0, 7'd52, 52'h9_2314_0527_4459},
    {1'b0, 7'd28, 52'hA_5F0C_3391_0ED2},
    {1'b0, 7'd60, 52'h3_C6A1_F00F_5A5A},
    {1'b1, 7'd52, 52'h4_9917_0312_5830},
    {1'b1, 7'd30, 52'hF_FFFF_0000_FFFF},
    {1'b1, 7'd58, 52'h1_2481_2481_2481},
    {1'b0, 7'd52, 52'hE_DB97_5310_ECA8}
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  task automatic read_frame(input logic [W-1:0] img, input int n);
    logic [W-1:0] shown;
    time_img_i = img;
    ce_i = 1'b1; dir_i = 1'b0;
    wait_n(HALF);
    chk(sdat_oe_o == 1'b1, "R2 oe in read", 64'(sdat_oe_o), 64'd1);
    for (int k = 1; k <= n; k++) begin
      sclk_i = 1'b1;
      wait_n(HALF);
      if (k == 1) time_img_i = ~img;   // R3 snapshot must hold
      shown = (k <= W) ? img : img;
      if (k <= W)
        chk(sdat_o == shown[k-1], "R3 read bit", 64'(sdat_o), 64'(shown[k-1]));
      else
        chk(sdat_o == shown[W-1], "R4 read after frame", 64'(sdat_o), 64'(shown[W-1]));
      sclk_i = 1'b0;
      wait_n(HALF);
    end
    chk(carry_hold_o == 1'b0, "R9 no hold in read", 64'(carry_hold_o), 64'd0);
    ce_i = 1'b0;
    wait_n(HALF);
    chk(sdat_oe_o == 1'b0, "R2 oe off with ce low", 64'(sdat_oe_o), 64'd0);
  endtask

  task automatic write_frame(input logic [W-1:0] img, input int n);
    int c0, d0;
    c0 = commits; d0 = divs;
    ce_i = 1'b1; dir_i = 1'b1;
    wait_n(HALF);
    chk(sdat_oe_o == 1'b0, "R2 oe off in write", 64'(sdat_oe_o), 64'd0);
    for (int k = 0; k < n; k++) begin
      sdat_i = (k < W) ? img[k] : ~img[k-W];
      wait_n(4);
      sclk_i = 1'b1;
      wait_n(HALF);
      sclk_i = 1'b0;
      wait_n(HALF);
      if (k == 0) begin
        chk(divs - d0 == 1, "R9 divider reset pulse", 64'(divs - d0), 64'd1);
        chk(carry_hold_o == 1'b1, "R9 hold raised", 64'(carry_hold_o), 64'd1);
      end
    end
    chk(divs - d0 == 1, "R9 single divider reset", 64'(divs - d0), 64'd1);
    chk(carry_hold_o == 1'b1, "R9 hold kept", 64'(carry_hold_o), 64'd1);
    ce_i = 1'b0;
    wait_n(HALF);
    chk(carry_hold_o == 1'b0, "R9 hold released", 64'(carry_hold_o), 64'd0);
    if (n >= W) begin
      last_img = img;
      chk(commits - c0 == 1, "R6 R7 one commit", 64'(commits - c0), 64'd1);
    end else begin
      chk(commits - c0 == 0, "R8 no commit", 64'(commits - c0), 64'd0);
    end
    chk(wr_img_o == last_img, "R6 R7 R8 image", 64'(wr_img_o), 64'(last_img));
  endtask

  initial begin
    wait (cycles > 200000);
    chk(1'b0, "watchdog", 64'(cycles), 64'd200000);
    done();
  end

  initial begin
    rst_n = 1'b0;
    ce_i = 1'b0; dir_i = 1'b0; sclk_i = 1'b0; sdat_i = 1'b0;
    time_img_i = '0;
    last_img = '0;
    wait_n(5);
    // R1 reset state
    chk(sdat_oe_o == 1'b0, "R1 oe", 64'(sdat_oe_o), 64'd0);
    chk(wr_commit_o == 1'b0 && div_rst_o == 1'b0, "R1 pulses", 64'({wr_commit_o, div_rst_o}), 64'd0);
    chk(carry_hold_o == 1'b0, "R1 hold", 64'(carry_hold_o), 64'd0);
    chk(wr_img_o == '0, "R1 image", 64'(wr_img_o), 64'd0);
    rst_n = 1'b1;
    wait_n(4);

    for (int v = 0; v < 7; v++) begin
      if (VEC[v][59]) write_frame(VEC[v][51:0], int'(VEC[v][58:52]));
      else            read_frame(VEC[v][51:0], int'(VEC[v][58:52]));
      wait_n(HALF);
    end

    // R10: activity with ce low is ignored
    begin
      int c0, d0;
      c0 = commits; d0 = divs;
      dir_i = 1'b1;
      for (int k = 0; k < 60; k++) begin
        sdat_i = k[0];
        sclk_i = 1'b1; wait_n(HALF);
        sclk_i = 1'b0; wait_n(HALF);
        if (sdat_oe_o) chk(1'b0, "R10 oe with ce low", 64'd1, 64'd0);
      end
      chk(commits == c0 && divs == d0, "R10 no pulses", 64'(commits - c0 + divs - d0), 64'd0);
      chk(carry_hold_o == 1'b0, "R10 no hold", 64'(carry_hold_o), 64'd0);
      chk(wr_img_o == last_img, "R10 image kept", 64'(wr_img_o), 64'(last_img));
    end

    // R5: truncated read, then a full read starts at bit 0 with fresh capture
    read_frame(52'h5_5555_AAAA_0F0F, 5);
    wait_n(HALF);
    read_frame(52'h0_1234_5678_9ABC, 52);

    done();
  end
endmodule